// File: doc/BRIEF.md
# DMA Channel Address and Count Unit

This block is the address and transfer-count datapath of a four-channel DMA controller. Each channel keeps a base and a current copy of a 16-bit transfer address and of a 16-bit transfer count. The CPU reaches all of them through an 8-bit data port. A shared byte-order flip-flop decides whether an access touches the low or the high byte. A CPU write loads the base copy and the current copy together. A CPU read returns the current copy.

When the sequencer pulses the transfer strobe for a channel, that channel steps its address and lowers its count. The step is one for a channel set to bytes and two for a channel set to words, and the address moves up or down according to the channel's direction bit. When the count passes below zero, the block gives a one-cycle terminal-count pulse. An end-of-process strobe restores the current copies from the base copies if the channel has autoinitialize set. The transfer address presented to the bus has bit 0 forced to zero on word channels. In memory-to-memory operation an address-hold control freezes the address of channel 0.

Top module: `dma_addr_count_unit`

## Requirements
- R1: After reset every base and current register reads 0, the byte flip-flop points at the low byte, and `tc` is low.
- R2: The byte flip-flop starts on the low byte and toggles on each CPU read or write. `ptr_clr` or `mclr` returns it to the low byte.
- R3: A CPU write (`cpu_sel_cnt`=0 address, 1 count) loads the addressed byte of both the base and the current copy. A CPU read returns that byte of the current copy on `cpu_rdata`.
- R4: A transfer moves the current address of channel `xfer_ch` by 1 when `ch_wide` is 0 and by 2 when it is 1. The address increments when `ch_down` is 0 and decrements when it is 1, and it wraps modulo 2^16.
- R5: `xfer_addr` is the current address of channel `xfer_ch`, with bit 0 forced to 0 when that channel's `ch_wide` bit is 1.
- R6: A transfer lowers the current count by 1 on a byte channel and by 2 on a word channel, modulo 2^16.
- R7: `tc` is high for exactly the one cycle after a transfer whose count decrement passes below zero. The count is then left at FFFFh on a byte channel and, from an even start, at FFFEh on a word channel.
- R8: A byte channel loaded with count n completes n+1 transfers up to and including the one that raises `tc`. A word channel completes n/2+1 transfers for even n and (n+1)/2 transfers for odd n.
- R9: `eop` on channel `xfer_ch` with its `ch_autoinit` bit set reloads the current address and count from the base copies, and the reload takes precedence over a transfer in the same cycle. Without autoinitialize, `eop` changes nothing.
- R10: When `mem2mem` and `addr_hold` are both 1, transfers on channel 0 leave its address unchanged while its count still decrements. Other channels, and channel 0 with `mem2mem` at 0, step as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mclr | input | 1 | Master clear strobe (resets the byte flip-flop) |
| ptr_clr | input | 1 | Clear-byte-pointer command strobe |
| cpu_wr | input | 1 | CPU byte write strobe |
| cpu_rd | input | 1 | CPU byte read strobe |
| cpu_ch | input | 2 | Channel addressed by the CPU |
| cpu_sel_cnt | input | 1 | 0 selects the address register, 1 selects the count register |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Selected byte of the current register |
| ch_wide | input | 4 | Per channel: 1 for word transfers, 0 for byte transfers |
| ch_down | input | 4 | Per channel: 1 to decrement the address, 0 to increment it |
| ch_autoinit | input | 4 | Per channel autoinitialize enable |
| mem2mem | input | 1 | Memory-to-memory operation active |
| addr_hold | input | 1 | Freeze the channel 0 address during memory-to-memory operation |
| xfer | input | 1 | Transfer strobe |
| xfer_ch | input | 2 | Channel for the transfer and end-of-process strobes |
| eop | input | 1 | End-of-process strobe |
| xfer_addr | output | 16 | Transfer address of channel `xfer_ch` |
| tc | output | 1 | Terminal-count pulse |

## Verification
A wrong step size or a wrong direction shows on `xfer_addr` in the cycle right after the faulty transfer, and it also shows on a two-byte readback. A byte flip-flop that is out of phase swaps the bytes of the next 16-bit write or read, so the error appears within two accesses. A wrong wrap threshold moves the `tc` pulse by one transfer, which is visible as a transfer total that is off by one. A missed reload shows on the first readback after `eop`.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned WORD_W = 2 * BYTE_W;

  // Next transfer address: one byte or one word, up or down.
  function automatic logic [WORD_W-1:0] next_addr(input logic [WORD_W-1:0] a,
                                                  input logic wide, input logic down);
    logic [WORD_W-1:0] step;
    step = wide ? WORD_W'(2) : WORD_W'(1);
    return down ? a - step : a + step;
  endfunction

  // Count decrement; the top bit is the borrow that marks terminal count.
  function automatic logic [WORD_W:0] dec_count(input logic [WORD_W-1:0] c,
                                                 input logic wide);
    logic [WORD_W:0] step;
    step = wide ? (WORD_W+1)'(2) : (WORD_W+1)'(1);
    return {1'b0, c} - step;
  endfunction
endpackage

// File: rtl/dmac_byte_ptr.sv
module dmac_byte_ptr (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step,
  output logic hi
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) hi <= 1'b0;
    else if (step)     hi <= ~hi;
  end

  p_toggle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !clr) |=> (hi != $past(hi)));
  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !hi);
endmodule

// File: rtl/dmac_channel.sv
module dmac_channel
  import dmac_pkg::*;
#(
  parameter int unsigned DW = BYTE_W,
  localparam int unsigned AW = 2 * DW
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_cnt,
  input  logic          wr_hi,
  input  logic [DW-1:0] wdata,
  input  logic          xfer_en,
  input  logic          eop_en,
  input  logic          wide,
  input  logic          down,
  input  logic          autoinit,
  input  logic          hold,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] cur_cnt,
  output logic          wrap
);
  logic [AW-1:0] base_addr, base_cnt;
  logic [AW:0]   cnt_dec;
  logic          reload;

  assign cnt_dec = dec_count(cur_cnt, wide);
  assign reload  = eop_en && autoinit;
  assign wrap    = xfer_en && !wr_en && cnt_dec[AW];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_addr <= '0;
      cur_addr  <= '0;
      base_cnt  <= '0;
      cur_cnt   <= '0;
    end else if (wr_en) begin
      if (!wr_cnt && !wr_hi) begin base_addr[DW-1:0]  <= wdata; cur_addr[DW-1:0]  <= wdata; end
      if (!wr_cnt &&  wr_hi) begin base_addr[AW-1:DW] <= wdata; cur_addr[AW-1:DW] <= wdata; end
      if ( wr_cnt && !wr_hi) begin base_cnt[DW-1:0]   <= wdata; cur_cnt[DW-1:0]   <= wdata; end
      if ( wr_cnt &&  wr_hi) begin base_cnt[AW-1:DW]  <= wdata; cur_cnt[AW-1:DW]  <= wdata; end
    end else if (reload) begin
      cur_addr <= base_addr;
      cur_cnt  <= base_cnt;
    end else if (xfer_en) begin
      if (!hold) cur_addr <= next_addr(cur_addr, wide, down);
      cur_cnt <= cnt_dec[AW-1:0];
    end
  end

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_en && hold && !wr_en && !reload) |=> $stable(cur_addr));
  p_word_lsb_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_en && wide && !wr_en && !reload) |=> (cur_addr[0] == $past(cur_addr[0])));
  p_reload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (reload && !wr_en) |=> (cur_cnt == $past(base_cnt) && cur_addr == $past(base_addr)));
  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |-> (cur_cnt <= (wide ? AW'(1) : AW'(0))));
endmodule

// File: rtl/dma_addr_count_unit.sv
module dma_addr_count_unit
  import dmac_pkg::*;
#(
  parameter int unsigned N_CH = 4,
  parameter int unsigned DW   = BYTE_W,
  localparam int unsigned AW  = 2 * DW,
  localparam int unsigned CW  = $clog2(N_CH)
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mclr,
  input  logic            ptr_clr,
  input  logic            cpu_wr,
  input  logic            cpu_rd,
  input  logic [CW-1:0]   cpu_ch,
  input  logic            cpu_sel_cnt,
  input  logic [DW-1:0]   cpu_wdata,
  output logic [DW-1:0]   cpu_rdata,
  input  logic [N_CH-1:0] ch_wide,
  input  logic [N_CH-1:0] ch_down,
  input  logic [N_CH-1:0] ch_autoinit,
  input  logic            mem2mem,
  input  logic            addr_hold,
  input  logic            xfer,
  input  logic [CW-1:0]   xfer_ch,
  input  logic            eop,
  output logic [AW-1:0]   xfer_addr,
  output logic            tc
);
  logic            ptr_hi;
  logic [AW-1:0]   addr_q [N_CH];
  logic [AW-1:0]   cnt_q  [N_CH];
  logic [N_CH-1:0] wrap_v;
  logic [AW-1:0]   rd_word, sel_addr;

  dmac_byte_ptr u_ptr (
    .clk(clk), .rst_n(rst_n), .clr(mclr || ptr_clr),
    .step(cpu_wr || cpu_rd), .hi(ptr_hi)
  );

  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic hold_c;
    if (c == 0) begin : g_hold
      assign hold_c = mem2mem && addr_hold;
    end else begin : g_free
      assign hold_c = 1'b0;
    end
    dmac_channel #(.DW(DW)) u_ch (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cpu_wr && cpu_ch == CW'(c)), .wr_cnt(cpu_sel_cnt), .wr_hi(ptr_hi),
      .wdata(cpu_wdata),
      .xfer_en(xfer && xfer_ch == CW'(c)), .eop_en(eop && xfer_ch == CW'(c)),
      .wide(ch_wide[c]), .down(ch_down[c]), .autoinit(ch_autoinit[c]),
      .hold(hold_c),
      .cur_addr(addr_q[c]), .cur_cnt(cnt_q[c]), .wrap(wrap_v[c])
    );
  end

  assign rd_word   = cpu_sel_cnt ? cnt_q[cpu_ch] : addr_q[cpu_ch];
  assign cpu_rdata = ptr_hi ? rd_word[AW-1:DW] : rd_word[DW-1:0];
  assign sel_addr  = addr_q[xfer_ch];
  assign xfer_addr = {sel_addr[AW-1:1], sel_addr[0] & ~ch_wide[xfer_ch]};

  always_ff @(posedge clk) begin
    if (!rst_n) tc <= 1'b0;
    else        tc <= |wrap_v;
  end

  p_a0_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ch_wide[xfer_ch] |-> !xfer_addr[0]);
  p_tc_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> $past(xfer));
  p_wrap_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wrap_v));
endmodule

// File: tb/dma_addr_count_unit_test.sv
module dma_addr_count_unit_test;
  logic clk = 1'b0, rst_n = 1'b0, mclr = 1'b0, ptr_clr = 1'b0;
  logic cpu_wr = 1'b0, cpu_rd = 1'b0, cpu_sel_cnt = 1'b0;
  logic [1:0] cpu_ch = '0, xfer_ch = '0;
  logic [7:0] cpu_wdata = '0, cpu_rdata;
  logic [3:0] ch_wide = '0, ch_down = '0, ch_autoinit = '0;
  logic mem2mem = 1'b0, addr_hold = 1'b0, xfer = 1'b0, eop = 1'b0, tc;
  logic [15:0] xfer_addr;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  dma_addr_count_unit uut (.*);

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, got, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [1:0] ch, input logic sc,
                     input logic [7:0] d, output logic [7:0] q);
    @(negedge clk);
    cpu_wr = wr; cpu_rd = !wr; cpu_ch = ch; cpu_sel_cnt = sc; cpu_wdata = d;
    #1 q = cpu_rdata;
    @(negedge clk);
    cpu_wr = 1'b0; cpu_rd = 1'b0;
  endtask

  task automatic wr16(input logic [1:0] ch, input logic sc, input logic [15:0] v);
    logic [7:0] q;
    acc(1'b1, ch, sc, v[7:0], q);
    acc(1'b1, ch, sc, v[15:8], q);
  endtask

  task automatic rd16(input logic [1:0] ch, input logic sc, output logic [15:0] v);
    logic [7:0] lo, hi;
    acc(1'b0, ch, sc, 8'h00, lo);
    acc(1'b0, ch, sc, 8'h00, hi);
    v = {hi, lo};
  endtask

  task automatic pulse_clr(input logic master);
    @(negedge clk);
    if (master) mclr = 1'b1; else ptr_clr = 1'b1;
    @(negedge clk);
    mclr = 1'b0; ptr_clr = 1'b0;
  endtask

  // one transfer strobe; returns address seen during it and tc afterwards
  task automatic do_xfer(input logic [1:0] ch, input logic with_eop,
                         output logic [15:0] a, output logic t);
    @(negedge clk);
    xfer = 1'b1; xfer_ch = ch; eop = with_eop;
    #1 a = xfer_addr;
    @(negedge clk);
    xfer = 1'b0; eop = 1'b0;
    #1 t = tc;
  endtask

  task automatic do_eop(input logic [1:0] ch);
    @(negedge clk);
    eop = 1'b1; xfer_ch = ch;
    @(negedge clk);
    eop = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    check("R1 tc", int'(tc), 0);
    rd16(2'd3, 1'b0, v); check("R1 addr", int'(v), 0);
    rd16(2'd1, 1'b1, v); check("R1 count", int'(v), 0);
  endtask

  task automatic t_bytes;
    logic [15:0] v; logic [7:0] q;
    wr16(2'd1, 1'b0, 16'h1234);
    rd16(2'd1, 1'b0, v); check("R3 write/read", int'(v), 16'h1234);
    acc(1'b1, 2'd2, 1'b0, 8'h77, q);   // pointer left on high byte
    pulse_clr(1'b0);
    wr16(2'd2, 1'b0, 16'hABCD);
    rd16(2'd2, 1'b0, v); check("R2 ptr_clr", int'(v), 16'hABCD);
    acc(1'b1, 2'd2, 1'b1, 8'h55, q);
    pulse_clr(1'b1);
    wr16(2'd2, 1'b1, 16'h0F0E);
    rd16(2'd2, 1'b1, v); check("R2 mclr", int'(v), 16'h0F0E);
  endtask

  task automatic t_step;
    logic [15:0] a, v; logic t;
    ch_wide = 4'b0000; ch_down = 4'b0000;
    wr16(2'd2, 1'b0, 16'h0100); wr16(2'd2, 1'b1, 16'h0050);
    do_xfer(2'd2, 1'b0, a, t); check("R5 byte addr", int'(a), 16'h0100);
    rd16(2'd2, 1'b0, v); check("R4 byte up", int'(v), 16'h0101);
    rd16(2'd2, 1'b1, v); check("R6 byte count", int'(v), 16'h004F);
    ch_down[2] = 1'b1;
    wr16(2'd2, 1'b0, 16'h0000);
    do_xfer(2'd2, 1'b0, a, t);
    rd16(2'd2, 1'b0, v); check("R4 byte down wrap", int'(v), 16'hFFFF);
    ch_wide[2] = 1'b1; ch_down[2] = 1'b0;
    wr16(2'd2, 1'b0, 16'h0201); wr16(2'd2, 1'b1, 16'h000A);
    do_xfer(2'd2, 1'b0, a, t); check("R5 word A0 low", int'(a), 16'h0200);
    rd16(2'd2, 1'b0, v); check("R4 word up", int'(v), 16'h0203);
    rd16(2'd2, 1'b1, v); check("R6 word count", int'(v), 16'h0008);
    ch_down[2] = 1'b1;
    do_xfer(2'd2, 1'b0, a, t); check("R5 word A0 odd", int'(a), 16'h0202);
    rd16(2'd2, 1'b0, v); check("R4 word down", int'(v), 16'h0201);
    ch_down[2] = 1'b0; ch_wide[2] = 1'b0;
  endtask

  task automatic run_tc(input logic wide, input logic [15:0] n, input int exp_n,
                        input int exp_end, input string tag);
    logic [15:0] a, v; logic t; int k;
    ch_wide[3] = wide;
    wr16(2'd3, 1'b1, n);
    k = 0; t = 1'b0;
    while (!t && k < 40) begin
      do_xfer(2'd3, 1'b0, a, t);
      k++;
    end
    check({tag, " transfers"}, k, exp_n);
    @(negedge clk); check("R7 tc one cycle", int'(tc), 0);
    rd16(2'd3, 1'b1, v); check({tag, " end count"}, int'(v), exp_end);
  endtask

  task automatic t_tc;
    run_tc(1'b0, 16'd3, 4, 16'hFFFF, "R8 byte n=3");
    run_tc(1'b1, 16'd4, 3, 16'hFFFE, "R8 word n=4");
    run_tc(1'b1, 16'd5, 3, 16'hFFFF, "R8 word n=5");
    run_tc(1'b0, 16'd0, 1, 16'hFFFF, "R7 byte n=0");
    ch_wide[3] = 1'b0;
  endtask

  task automatic t_auto;
    logic [15:0] a, v; logic t;
    ch_autoinit = 4'b0010;
    wr16(2'd1, 1'b0, 16'h4000); wr16(2'd1, 1'b1, 16'h0002);
    do_xfer(2'd1, 1'b0, a, t); do_xfer(2'd1, 1'b0, a, t);
    do_eop(2'd1);
    rd16(2'd1, 1'b0, v); check("R9 reload addr", int'(v), 16'h4000);
    rd16(2'd1, 1'b1, v); check("R9 reload count", int'(v), 16'h0002);
    do_xfer(2'd1, 1'b1, a, t);
    rd16(2'd1, 1'b1, v); check("R9 eop beats xfer", int'(v), 16'h0002);
    ch_autoinit = 4'b0000;
    do_xfer(2'd1, 1'b0, a, t);
    do_eop(2'd1);
    rd16(2'd1, 1'b0, v); check("R9 no autoinit addr", int'(v), 16'h4001);
    rd16(2'd1, 1'b1, v); check("R9 no autoinit count", int'(v), 16'h0001);
  endtask

  task automatic t_hold;
    logic [15:0] a, v; logic t;
    mem2mem = 1'b1; addr_hold = 1'b1;
    wr16(2'd0, 1'b0, 16'h0800); wr16(2'd0, 1'b1, 16'h0010);
    do_xfer(2'd0, 1'b0, a, t);
    rd16(2'd0, 1'b0, v); check("R10 ch0 held", int'(v), 16'h0800);
    rd16(2'd0, 1'b1, v); check("R10 ch0 count moves", int'(v), 16'h000F);
    wr16(2'd1, 1'b0, 16'h0900);
    do_xfer(2'd1, 1'b0, a, t);
    rd16(2'd1, 1'b0, v); check("R10 ch1 not held", int'(v), 16'h0901);
    mem2mem = 1'b0;
    do_xfer(2'd0, 1'b0, a, t);
    rd16(2'd0, 1'b0, v); check("R10 hold needs mem2mem", int'(v), 16'h0801);
    addr_hold = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bytes();
    t_step();
    t_tc();
    t_auto();
    t_hold();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule